// File: doc/BRIEF.md
# Flash Configuration and Protection Register Block

This block holds the two control registers that sit beside a flash controller's command engine. It has a byte-wide register bus with an address, a write strobe, write data and combinational read data. The configuration register holds two interrupt enables and the backdoor-key access bit. The protection register holds an open-protection bit, a reserved bit, and two region descriptors. Each region descriptor is a disable bit plus a two-bit size. The block merges the interrupt enables with the controller's buffer-empty and command-complete flags into one interrupt request. It sends every field value to the controller core on dedicated outputs.

Every field of the protection register starts from a nonvolatile value that is presented on an input and captured while reset is held. Each protection field can afterwards only be tightened. Each protection region is a small state machine with two states. `RGN_ADJUSTABLE` means the disable bit is 1 and the size field accepts writes. `RGN_FROZEN` means the disable bit is 0 and the size field is locked. The transition `lock` goes from `RGN_ADJUSTABLE` to `RGN_FROZEN` on a protection write whose disable bit is 0. `RGN_FROZEN` keeps its state until reset, and reset enters whichever state the nonvolatile disable bit names.

The key-access bit is also a two-state machine. `ACC_COMMAND` means array writes start command sequences. `ACC_BACKDOOR` means array writes go to the backdoor-key path and array reads are invalid. The transition `enter_key` goes from `ACC_COMMAND` to `ACC_BACKDOOR` on a configuration write with bit 5 set while the key-enable input is high. The transition `leave_key` goes from `ACC_BACKDOOR` to `ACC_COMMAND` on such a write with bit 5 clear. Reset enters `ACC_COMMAND`.

Top module: `flcfg_regs`

## Requirements
- R1: The configuration register is at offset 0x03. After reset it reads 0x00, and its bits 4..0 always read 0.
- R2: A write to offset 0x03 loads bit 7 (buffer-empty interrupt enable) and bit 6 (command-complete interrupt enable) unconditionally, and bits 4..0 of the written data are ignored.
- R3: Bit 5 of the configuration register (key access) takes the written value only when `key_en` is 1 at the time of the write. Otherwise it keeps its value. `backdoor_mode` equals this bit.
- R4: `irq` is 1 exactly when (`buf_empty_flag` and bit 7 of the configuration register) or (`cmd_done_flag` and bit 6 of the configuration register).
- R5: The protection register is at offset 0x04. While reset is held, all eight of its bits are loaded from `nv_prot`.
- R6: Protection bit 7 (open) changes only from 1 to 0. A write of 0 clears it, and a write of 1 leaves it unchanged.
- R7: Protection bit 6 (reserved), bit 5 (high-region disable) and bit 2 (low-region disable) also change only from 1 to 0 on writes.
- R8: The low size, protection bits 1..0, takes the written value only if the low-region disable bit was 1 before that write. This includes the write that clears the disable bit. After that, the field is locked until reset.
- R9: The high size, protection bits 4..3, follows the same rule with the high-region disable bit.
- R10: Reads of any other offset return 0x00. Writes to any other offset change neither register.
- R11: The field outputs always equal the corresponding register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| key_en | input | 1 | External enable for writing the key-access bit |
| nv_prot | input | 8 | Nonvolatile reset image of the protection register |
| buf_empty_flag | input | 1 | Command buffer empty flag from the controller |
| cmd_done_flag | input | 1 | All commands complete flag from the controller |
| irq | output | 1 | Combined interrupt request |
| backdoor_mode | output | 1 | Array accesses go to the backdoor-key path |
| buf_empty_ie | output | 1 | Buffer-empty interrupt enable |
| cmd_done_ie | output | 1 | Command-complete interrupt enable |
| prot_open | output | 1 | Open-protection bit |
| prot_rsvd | output | 1 | Reserved nonvolatile bit |
| hi_disable | output | 1 | High-region protection disable |
| hi_size | output | 2 | High-region size |
| lo_disable | output | 1 | Low-region protection disable |
| lo_size | output | 2 | Low-region size |

## Verification
Protection writes are tried with an all-ones value after each field has been cleared. This shows whether a bit can be set again. Writes that clear a disable bit and change its size in the same cycle show whether the pre-write value or the post-write value of the disable bit gates the size field. Configuration writes of all ones and all zeros are repeated with `key_en` low and with it high. This separates the gated key bit from the two free enables. Each flag-and-enable combination shows whether the interrupt path is an AND/OR and not a plain OR of the flags. A second reset with a different nonvolatile image shows that the reset value comes from the input and not from a constant.

// File: rtl/flcfg_pkg.sv
package flcfg_pkg;

    localparam int REG_W       = 8;
    localparam int RGN_SIZE_W  = 2;
    localparam int RGN_FIELD_W = RGN_SIZE_W + 1;
    localparam int RGN_COUNT   = 2;

    // configuration register bit positions
    localparam int CFG_BEIE_BIT = 7;
    localparam int CFG_CCIE_BIT = 6;
    localparam int CFG_KEY_BIT  = 5;

    // protection register bit positions
    localparam int PROT_OPEN_BIT = 7;
    localparam int PROT_RSVD_BIT = 6;

    // region index 0 = low region (bits 2..0), index 1 = high region (bits 5..3)
    localparam int RGN_LO = 0;
    localparam int RGN_HI = 1;

    typedef enum logic [0:0] {
        RGN_FROZEN     = 1'b0,
        RGN_ADJUSTABLE = 1'b1
    } rgn_state_t;

    typedef enum logic [0:0] {
        ACC_COMMAND  = 1'b0,
        ACC_BACKDOOR = 1'b1
    } acc_state_t;

endpackage

// File: rtl/flcfg_cfg_reg.sv
module flcfg_cfg_reg
    import flcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_beie,
    input  logic wr_ccie,
    input  logic wr_key,
    input  logic key_en,
    output logic beie_o,
    output logic ccie_o,
    output logic key_o
);

    logic       beie_q;
    logic       ccie_q;
    acc_state_t acc_q;
    acc_state_t acc_d;

    // next state of the key-access machine
    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_COMMAND: begin
                if (wr_en && key_en && wr_key) begin
                    acc_d = ACC_BACKDOOR;   // enter_key
                end
            end
            ACC_BACKDOOR: begin
                if (wr_en && key_en && !wr_key) begin
                    acc_d = ACC_COMMAND;    // leave_key
                end
            end
            default: acc_d = ACC_COMMAND;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_COMMAND;
            beie_q <= 1'b0;
            ccie_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            if (wr_en) begin
                beie_q <= wr_beie;
                ccie_q <= wr_ccie;
            end
        end
    end

    // outputs
    always_comb begin
        beie_o = beie_q;
        ccie_o = ccie_q;
        key_o  = (acc_q == ACC_BACKDOOR);
    end

    AST_KEY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !key_en |=> $stable(key_o));                                       // R3
    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (beie_o == $past(wr_beie)) && (ccie_o == $past(wr_ccie))); // R2

endmodule

// File: rtl/flcfg_region_ctl.sv
module flcfg_region_ctl
    import flcfg_pkg::*;
#(
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_dis,
    input  logic [SIZE_W-1:0] nv_size,
    input  logic              wr_en,
    input  logic              wr_dis,
    input  logic [SIZE_W-1:0] wr_size,
    output logic              disable_o,
    output logic [SIZE_W-1:0] size_o
);

    rgn_state_t        state_q;
    rgn_state_t        state_d;
    logic [SIZE_W-1:0] size_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RGN_ADJUSTABLE: begin
                if (wr_en && !wr_dis) begin
                    state_d = RGN_FROZEN;   // lock
                end
            end
            RGN_FROZEN: state_d = RGN_FROZEN;
            default:    state_d = RGN_FROZEN;
        endcase
    end

    // state register; size is gated by the state before the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= nv_dis ? RGN_ADJUSTABLE : RGN_FROZEN;
            size_q  <= nv_size;
        end else begin
            state_q <= state_d;
            if (wr_en && (state_q == RGN_ADJUSTABLE)) begin
                size_q <= wr_size;
            end
        end
    end

    // outputs
    always_comb begin
        disable_o = (state_q == RGN_ADJUSTABLE);
        size_o    = size_q;
    end

    AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !disable_o |=> $stable(size_o));                 // R8
    AST_NO_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disable_o |=> !disable_o);                      // R7

endmodule

// File: rtl/flcfg_prot_reg.sv
module flcfg_prot_reg
    import flcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] nv_prot,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] prot_o
);

    logic open_q;
    logic rsvd_q;
    logic [RGN_COUNT-1:0]  rgn_dis;
    logic [RGN_SIZE_W-1:0] rgn_size [RGN_COUNT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= nv_prot[PROT_OPEN_BIT];
            rsvd_q <= nv_prot[PROT_RSVD_BIT];
        end else if (wr_en) begin
            open_q <= open_q & wr_data[PROT_OPEN_BIT];
            rsvd_q <= rsvd_q & wr_data[PROT_RSVD_BIT];
        end
    end

    for (genvar gi = 0; gi < RGN_COUNT; gi++) begin : g_rgn
        localparam int BASE = gi * RGN_FIELD_W;
        localparam int DBIT = BASE + RGN_SIZE_W;
        flcfg_region_ctl #(
            .SIZE_W (RGN_SIZE_W)
        ) i_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .nv_dis    (nv_prot[DBIT]),
            .nv_size   (nv_prot[BASE +: RGN_SIZE_W]),
            .wr_en     (wr_en),
            .wr_dis    (wr_data[DBIT]),
            .wr_size   (wr_data[BASE +: RGN_SIZE_W]),
            .disable_o (rgn_dis[gi]),
            .size_o    (rgn_size[gi])
        );
    end

    always_comb begin
        prot_o = {open_q, rsvd_q,
                  rgn_dis[RGN_HI], rgn_size[RGN_HI],
                  rgn_dis[RGN_LO], rgn_size[RGN_LO]};
    end

    AST_OPEN_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |=> !open_q);                                  // R6
    AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[PROT_OPEN_BIT]) |=> !open_q);       // R6
    AST_RSVD_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !rsvd_q |=> !rsvd_q);                                  // R7

endmodule

// File: rtl/flcfg_regs.sv
module flcfg_regs
    import flcfg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CFG_OFS  = 3,
    parameter int PROT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              key_en,
    input  logic [REG_W-1:0]  nv_prot,
    input  logic              buf_empty_flag,
    input  logic              cmd_done_flag,
    output logic              irq,
    output logic              backdoor_mode,
    output logic              buf_empty_ie,
    output logic              cmd_done_ie,
    output logic              prot_open,
    output logic              prot_rsvd,
    output logic              hi_disable,
    output logic [1:0]        hi_size,
    output logic              lo_disable,
    output logic [1:0]        lo_size
);

    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(PROT_OFS);

    logic sel_cfg;
    logic sel_prot;
    logic beie;
    logic ccie;
    logic keyacc;
    logic [REG_W-1:0] prot_val;
    logic [REG_W-1:0] cfg_val;

    always_comb begin
        sel_cfg  = (bus_addr == CFG_ADDR);
        sel_prot = (bus_addr == PROT_ADDR);
    end

    flcfg_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel_cfg),
        .wr_beie (bus_wdata[CFG_BEIE_BIT]),
        .wr_ccie (bus_wdata[CFG_CCIE_BIT]),
        .wr_key  (bus_wdata[CFG_KEY_BIT]),
        .key_en  (key_en),
        .beie_o  (beie),
        .ccie_o  (ccie),
        .key_o   (keyacc)
    );

    flcfg_prot_reg i_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_prot (nv_prot),
        .wr_en   (bus_we && sel_prot),
        .wr_data (bus_wdata),
        .prot_o  (prot_val)
    );

    always_comb begin
        cfg_val = '0;
        cfg_val[CFG_BEIE_BIT] = beie;
        cfg_val[CFG_CCIE_BIT] = ccie;
        cfg_val[CFG_KEY_BIT]  = keyacc;
    end

    always_comb begin
        if (sel_cfg) begin
            bus_rdata = cfg_val;
        end else if (sel_prot) begin
            bus_rdata = prot_val;
        end else begin
            bus_rdata = '0;
        end
    end

    always_comb begin
        irq           = (buf_empty_flag & beie) | (cmd_done_flag & ccie);
        backdoor_mode = keyacc;
        buf_empty_ie  = beie;
        cmd_done_ie   = ccie;
        prot_open     = prot_val[7];
        prot_rsvd     = prot_val[6];
        hi_disable    = prot_val[5];
        hi_size       = prot_val[4:3];
        lo_disable    = prot_val[2];
        lo_size       = prot_val[1:0];
    end

    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty_flag && !cmd_done_flag) |-> !irq);              // R4
    AST_CFG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cfg |-> (bus_rdata[4:0] == 5'b0));                      // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_cfg && !sel_prot) |-> (bus_rdata == '0));             // R10
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !sel_cfg && !sel_prot) |=> $stable(prot_val) && $stable(cfg_val)); // R10

endmodule

// File: tb/test_flcfg_regs.sv
module test_flcfg_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       key_en = 1'b0;
    logic [7:0] nv_prot = 8'hFF;
    logic       buf_empty_flag = 1'b0;
    logic       cmd_done_flag = 1'b0;
    logic       irq, backdoor_mode, buf_empty_ie, cmd_done_ie;
    logic       prot_open, prot_rsvd, hi_disable, lo_disable;
    logic [1:0] hi_size, lo_size;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flcfg_regs i_flcfg_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .key_en         (key_en),
        .nv_prot        (nv_prot),
        .buf_empty_flag (buf_empty_flag),
        .cmd_done_flag  (cmd_done_flag),
        .irq            (irq),
        .backdoor_mode  (backdoor_mode),
        .buf_empty_ie   (buf_empty_ie),
        .cmd_done_ie    (cmd_done_ie),
        .prot_open      (prot_open),
        .prot_rsvd      (prot_rsvd),
        .hi_disable     (hi_disable),
        .hi_size        (hi_size),
        .lo_disable     (lo_disable),
        .lo_size        (lo_size)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h, expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] nv);
        @(negedge clk);
        rst_n   = 1'b0;
        nv_prot = nv;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        nv_prot = ~nv;   // later changes of the input must not matter
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset_state();
        do_reset(8'hFF);
        rd_chk("R1", 8'h03, 8'h00);
        rd_chk("R5", 8'h04, 8'hFF);
        buf_empty_flag = 1'b1;
        cmd_done_flag  = 1'b1;
        #1;
        chk("R4", {7'b0, irq}, 8'h00);
        buf_empty_flag = 1'b0;
        cmd_done_flag  = 1'b0;
        chk("R3", {7'b0, backdoor_mode}, 8'h00);
    endtask

    task automatic t_config();
        key_en = 1'b0;
        do_write(8'h03, 8'hFF);
        rd_chk("R2", 8'h03, 8'hC0);
        chk("R3", {7'b0, backdoor_mode}, 8'h00);
        key_en = 1'b1;
        do_write(8'h03, 8'hFF);
        rd_chk("R3", 8'h03, 8'hE0);
        chk("R3", {7'b0, backdoor_mode}, 8'h01);
        key_en = 1'b0;
        do_write(8'h03, 8'h00);
        rd_chk("R3", 8'h03, 8'h20);
        chk("R11", {6'b0, buf_empty_ie, cmd_done_ie}, 8'h00);
        key_en = 1'b1;
        do_write(8'h03, 8'h1F);
        rd_chk("R2", 8'h03, 8'h00);
        key_en = 1'b0;
    endtask

    task automatic t_irq();
        do_write(8'h03, 8'hC0);
        buf_empty_flag = 1'b1; cmd_done_flag = 1'b0; #1;
        chk("R4", {7'b0, irq}, 8'h01);
        buf_empty_flag = 1'b0; cmd_done_flag = 1'b1; #1;
        chk("R4", {7'b0, irq}, 8'h01);
        buf_empty_flag = 1'b0; cmd_done_flag = 1'b0; #1;
        chk("R4", {7'b0, irq}, 8'h00);
        do_write(8'h03, 8'h40);
        buf_empty_flag = 1'b1; #1;
        chk("R4", {7'b0, irq}, 8'h00);
        cmd_done_flag = 1'b1; #1;
        chk("R4", {7'b0, irq}, 8'h01);
        do_write(8'h03, 8'h80);
        buf_empty_flag = 1'b0; #1;
        chk("R4", {7'b0, irq}, 8'h00);
        cmd_done_flag = 1'b0;
        do_write(8'h03, 8'h00);
    endtask

    task automatic t_protect();
        do_write(8'h04, 8'h7F);
        rd_chk("R6", 8'h04, 8'h7F);
        do_write(8'h04, 8'hFF);
        rd_chk("R6", 8'h04, 8'h7F);
        do_write(8'h04, 8'h7C);
        rd_chk("R8", 8'h04, 8'h7C);
        do_write(8'h04, 8'h79);   // clear low disable and set low size in one write
        rd_chk("R8", 8'h04, 8'h79);
        do_write(8'h04, 8'h7F);
        rd_chk("R7", 8'h04, 8'h79);
        do_write(8'h04, 8'h41);   // clear high disable, high size 00
        rd_chk("R9", 8'h04, 8'h41);
        do_write(8'h04, 8'h7F);
        rd_chk("R9", 8'h04, 8'h41);
        do_write(8'h04, 8'h00);
        rd_chk("R7", 8'h04, 8'h01);
        do_write(8'h04, 8'hFF);
        rd_chk("R7", 8'h04, 8'h01);
        chk("R11", {prot_open, prot_rsvd, hi_disable, hi_size, lo_disable, lo_size}, 8'h01);
    endtask

    task automatic t_unmapped();
        do_reset(8'hFF);
        do_write(8'h03, 8'hC0);
        rd_chk("R10", 8'h05, 8'h00);
        do_write(8'h05, 8'h00);
        do_write(8'h02, 8'h00);
        rd_chk("R10", 8'h03, 8'hC0);
        rd_chk("R10", 8'h04, 8'hFF);
        do_write(8'h03, 8'h00);
        rd_chk("R10", 8'h04, 8'hFF);
    endtask

    task automatic t_nv_image();
        do_reset(8'h5A);
        rd_chk("R5", 8'h04, 8'h5A);
        chk("R11", {prot_open, prot_rsvd, hi_disable, hi_size, lo_disable, lo_size}, 8'h5A);
        do_write(8'h04, 8'hFF);
        rd_chk("R8", 8'h04, 8'h5A);
        rd_chk("R1", 8'h03, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_config();
        t_irq();
        t_protect();
        t_unmapped();
        t_nv_image();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule